// File: doc/BRIEF.md
# Interrupt Control Register Unit

This block is the 8-bit interrupt control and status register of a small microcontroller core. It holds a global enable, a second-level enable for the peripheral request group, and one enable each for three local sources: a timer rollover, an external interrupt pin and a six-pin port-change detector. For each local source it also holds a sticky flag.

A flag latches when its event happens, whatever the enable bits say. It stays set until software writes it back to 0. The block combines the flags, the enables and a peripheral request line into a single interrupt request to the core. The core's acknowledge drops the global enable, and its return-from-interrupt strobe raises it again.

The register sits on a simple read/write bus and answers at two mirrored addresses. The external pin and the port pins are asynchronous. They are resynchronised before edge and change detection. A separate per-pin mask selects which port pins can raise the port-change flag.

Top module: `int_ctrl_reg`

## Requirements
- R1: The register bits are, from bit 7 down to bit 0: global enable, peripheral enable, timer enable, pin enable, port enable, timer flag, pin flag, port flag. All bits are 0 after reset.
- R2: The register is selected when the low 7 bits of `addr_i` equal 0x0B, so both 0x0B and 0x8B select it. A write with `wr_en_i` high loads `wdata_i` at the next clock edge. `rdata_o` shows the register while it is selected and is 0 at any other address.
- R3: When `tmr_roll_i` is high at a clock edge, bit 2 is set at that edge, whatever the enable bits hold.
- R4: Bit 1 sets on a rising edge of `ext_pin_i`. A rise that is present before clock edge k shows in bit 1 after edge k+2. Enables do not affect this.
- R5: Bit 0 sets when a port pin whose `chg_mask_i` bit is 1 changes level, in either direction, with the same latency as R4. A pin whose mask bit is 0 never sets bit 0.
- R6: The flags (bits 2..0) hold until a register write puts 0 in them. If a set event and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R7: `irq_o` = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND `periph_req_i`)). It is combinational from the register and `periph_req_i`.
- R8: `ack_i` clears bit 7 at the next edge. `reti_i` sets it. `ack_i` wins over `reti_i`, and both win over a write to bit 7.
- R9: The enable bits 6..3 change only by register write and hold the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmr_roll_i | input | 1 | Timer rollover pulse, synchronous |
| ext_pin_i | input | 1 | External interrupt pin, asynchronous |
| port_i | input | 6 | Port pins, asynchronous |
| chg_mask_i | input | 6 | Per-pin change-detect mask |
| periph_req_i | input | 1 | Combined peripheral request |
| ack_i | input | 1 | Interrupt acknowledge from the core |
| reti_i | input | 1 | Return-from-interrupt strobe |
| addr_i | input | 8 | Bus address |
| wr_en_i | input | 1 | Bus write strobe |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Bus read data |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench drives a timer rollover and a write that clears the timer flag in the same cycle. A design that lets the write win would lose the event. It raises a port change on a masked-off pin next to one on an enabled pin, and a falling change as well as a rising one. A design that ignores the mask or detects only one direction would show a wrong port flag. It reads and writes through the mirror address and through an unrelated address. Partial decoding would appear as a stray write or as non-zero read data. Acknowledge, return and write arrive together on the global enable, where a wrong priority leaves `irq_o` asserted. Flags set with every enable off show that the flags are not gated, and the peripheral request is toggled with its group enable clear.

// File: rtl/icr_pkg.sv
package icr_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned B_GEN    = 7;
  localparam int unsigned B_PEN    = 6;
  localparam int unsigned B_TEN    = 5;
  localparam int unsigned B_XEN    = 4;
  localparam int unsigned B_CEN    = 3;
  localparam int unsigned B_TFLG   = 2;
  localparam int unsigned B_XFLG   = 1;
  localparam int unsigned B_CFLG   = 0;
  localparam int unsigned DEC_W    = 7;
  localparam logic [DEC_W-1:0] REG_LOC = 7'h0B;

  typedef struct packed {
    logic tmr;
    logic ext;
    logic chg;
  } icr_evt_t;
endpackage

// File: rtl/icr_sync.sv
module icr_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else            stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/icr_event_det.sv
module icr_event_det #(
  parameter int unsigned PORT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_s_i,
  input  logic [PORT_W-1:0] port_s_i,
  input  logic [PORT_W-1:0] mask_i,
  output logic              ext_rise_o,
  output logic              port_chg_o
);
  logic              ext_prev_q;
  logic [PORT_W-1:0] port_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_prev_q  <= 1'b0;
      port_prev_q <= '0;
    end else begin
      ext_prev_q  <= ext_s_i;
      port_prev_q <= port_s_i;
    end
  end

  assign ext_rise_o = ext_s_i & ~ext_prev_q;
  // either direction on any enabled pin
  assign port_chg_o = |((port_s_i ^ port_prev_q) & mask_i);
endmodule

// File: rtl/icr_regs.sv
module icr_regs
  import icr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  input  icr_evt_t         evt_i,
  input  logic             ack_i,
  input  logic             reti_i,
  output logic [REG_W-1:0] ctl_o
);
  logic [REG_W-1:0] ctl_q, ctl_d;

  always_comb begin
    ctl_d = wr_i ? wdata_i : ctl_q;
    // hardware set beats software clear
    if (evt_i.tmr) ctl_d[B_TFLG] = 1'b1;
    if (evt_i.ext) ctl_d[B_XFLG] = 1'b1;
    if (evt_i.chg) ctl_d[B_CFLG] = 1'b1;
    if (ack_i)       ctl_d[B_GEN] = 1'b0;
    else if (reti_i) ctl_d[B_GEN] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/int_ctrl_reg.sv
module int_ctrl_reg
  import icr_pkg::*;
#(
  parameter int unsigned PORT_W      = 6,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tmr_roll_i,
  input  logic              ext_pin_i,
  input  logic [PORT_W-1:0] port_i,
  input  logic [PORT_W-1:0] chg_mask_i,
  input  logic              periph_req_i,
  input  logic              ack_i,
  input  logic              reti_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int unsigned SYN_W = PORT_W + 1;

  logic [SYN_W-1:0] syn_s;
  logic             ext_rise, port_chg, sel;
  logic [REG_W-1:0] ctl;
  icr_evt_t         evt;

  icr_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ext_pin_i, port_i}),
    .q_o   (syn_s)
  );

  icr_event_det #(.PORT_W(PORT_W)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_s_i   (syn_s[SYN_W-1]),
    .port_s_i  (syn_s[PORT_W-1:0]),
    .mask_i    (chg_mask_i),
    .ext_rise_o(ext_rise),
    .port_chg_o(port_chg)
  );

  // top address bit ignored: mirrored decode
  assign sel = (addr_i[DEC_W-1:0] == REG_LOC);

  assign evt.tmr = tmr_roll_i;
  assign evt.ext = ext_rise;
  assign evt.chg = port_chg;

  icr_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_en_i & sel),
    .wdata_i(wdata_i),
    .evt_i  (evt),
    .ack_i  (ack_i),
    .reti_i (reti_i),
    .ctl_o  (ctl)
  );

  assign rdata_o = sel ? ctl : '0;
  assign irq_o   = ctl[B_GEN] & ((ctl[B_TEN] & ctl[B_TFLG]) |
                                 (ctl[B_XEN] & ctl[B_XFLG]) |
                                 (ctl[B_CEN] & ctl[B_CFLG]) |
                                 (ctl[B_PEN] & periph_req_i));
endmodule

// File: rtl/int_ctrl_reg_chk.sv
module int_ctrl_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tmr_roll_i,
  input logic       ack_i,
  input logic       reti_i,
  input logic [7:0] addr_i,
  input logic       wr_en_i,
  input logic [7:0] wdata_i,
  input logic [7:0] rdata_o,
  input logic       irq_o,
  input logic [7:0] ctl
);
  logic wr_hit;
  assign wr_hit = wr_en_i && (addr_i[6:0] == 7'h0B);

  AST_TMR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_roll_i |=> ctl[2]);  // R3

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl[2] && !wr_hit) |=> ctl[2]);  // R6

  AST_ACK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !ctl[7]);  // R8

  AST_RETI_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !ack_i) |=> ctl[7]);  // R8

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl[7] |-> !irq_o);  // R7

  AST_RD_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[6:0] != 7'h0B) |-> (rdata_o == 8'h00));  // R2

  AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(ctl[6:3]));  // R9
endmodule

bind int_ctrl_reg int_ctrl_reg_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tmr_roll_i(tmr_roll_i),
  .ack_i     (ack_i),
  .reti_i    (reti_i),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .irq_o     (irq_o),
  .ctl       (ctl)
);

// File: tb/sim_int_ctrl_reg.sv
`timescale 1ns/1ps
module sim_int_ctrl_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr = 1'b0, ext = 1'b0, preq = 1'b0, ack = 1'b0, reti = 1'b0, wr = 1'b0;
  logic [5:0] port = '0, mask = '0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0, errors = 0, cyc = 0;

  always #10 clk = ~clk;

  int_ctrl_reg u0 (
    .clk_i(clk), .rst_ni(rst_n), .tmr_roll_i(tmr), .ext_pin_i(ext),
    .port_i(port), .chg_mask_i(mask), .periph_req_i(preq), .ack_i(ack),
    .reti_i(reti), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  // reference model
  logic [7:0] m = '0;
  logic       ext_h [$] = '{1'b0, 1'b0, 1'b0};
  logic [5:0] port_h [$] = '{6'd0, 6'd0, 6'd0};

  always @(posedge clk) begin
    logic [7:0] n;
    logic rise, chg, hit;
    cyc++;
    if (!rst_n) begin
      m = '0;
      ext_h = '{1'b0, 1'b0, 1'b0};
      port_h = '{6'd0, 6'd0, 6'd0};
    end else begin
      hit  = (addr[6:0] == 7'h0B);
      rise = ext_h[1] && !ext_h[2];
      chg  = |((port_h[1] ^ port_h[2]) & mask);
      n = (wr && hit) ? wdata : m;
      if (tmr)  n[2] = 1'b1;
      if (rise) n[1] = 1'b1;
      if (chg)  n[0] = 1'b1;
      if (ack) n[7] = 1'b0; else if (reti) n[7] = 1'b1;
      m = n;
      ext_h.push_front(ext);   ext_h = ext_h[0:2];
      port_h.push_front(port); port_h = port_h[0:2];
    end
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d cycles, expected < 100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return m[7] & ((m[5] & m[2]) | (m[4] & m[1]) | (m[3] & m[0]) | (m[6] & preq));
  endfunction

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      if (addr[6:0] == 7'h0B) begin
        chk("R8", {7'd0, rdata[7]},   {7'd0, m[7]});
        chk("R9", {4'd0, rdata[6:3]}, {4'd0, m[6:3]});
        chk("R3", {7'd0, rdata[2]},   {7'd0, m[2]});
        chk("R4", {7'd0, rdata[1]},   {7'd0, m[1]});
        chk("R5", {7'd0, rdata[0]},   {7'd0, m[0]});
      end else begin
        chk("R2", rdata, 8'h00);
      end
      chk("R7", {7'd0, irq}, {7'd0, exp_irq()});
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    step();
    wr = 1'b0;
  endtask

  initial begin
    addr = 8'h0B;
    step(3);
    chk("R1", rdata, 8'h00);
    chk("R1", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    step();

    // enables via mirror address, read back at primary
    wr_reg(8'h8B, 8'h78);
    addr = 8'h0B; step();
    chk("R2", rdata, 8'h78);
    // unrelated address write ignored
    wr_reg(8'h0C, 8'hFF);
    addr = 8'h8B; step();
    chk("R2", rdata, 8'h78);

    // flags latch with every enable off
    wr_reg(8'h0B, 8'h00);
    tmr = 1'b1; step(); tmr = 1'b0;
    ext = 1'b1; port = 6'h01; mask = 6'h01; step(4);
    chk("R3", rdata, 8'h07);
    chk("R7", {7'd0, irq}, 8'h00);

    // sticky, then clear by write
    step(5);
    chk("R6", rdata, 8'h07);
    wr_reg(8'h0B, 8'h00); step();
    chk("R6", rdata, 8'h00);

    // set wins over clearing write
    wr_reg(8'h0B, 8'h04);
    tmr = 1'b1; wr_reg(8'h0B, 8'h00); tmr = 1'b0; step();
    chk("R6", rdata, 8'h04);

    // masked pin ignored, falling change on enabled pin detected
    wr_reg(8'h0B, 8'h00);
    mask = 6'h01; port = 6'h3F; step(5);
    chk("R5", rdata, 8'h00);
    port = 6'h3E; step(4);
    chk("R5", rdata, 8'h01);

    // irq composition and global enable control
    wr_reg(8'h0B, 8'hA1); step();
    chk("R7", {7'd0, irq}, 8'h00);
    wr_reg(8'h0B, 8'hB9); step();
    chk("R7", {7'd0, irq}, 8'h01);
    ack = 1'b1; reti = 1'b1; step(); ack = 1'b0; reti = 1'b0;
    chk("R8", {7'd0, irq}, 8'h00);
    reti = 1'b1; addr = 8'h0B; wdata = 8'h39; wr = 1'b1; step();
    wr = 1'b0; reti = 1'b0;
    chk("R8", rdata, 8'hB9);

    // peripheral group gate
    wr_reg(8'h0B, 8'h80); preq = 1'b1; step();
    chk("R7", {7'd0, irq}, 8'h00);
    wr_reg(8'h0B, 8'hC0); step();
    chk("R7", {7'd0, irq}, 8'h01);
    preq = 1'b0; step();

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      tmr  = ($urandom_range(0, 15) == 0);
      ext  = ($urandom_range(0, 7) == 0) ? ~ext : ext;
      if ($urandom_range(0, 5) == 0) port = port ^ (6'(1) << $urandom_range(0, 5));
      if ($urandom_range(0, 50) == 0) mask = 6'($urandom);
      preq = ($urandom_range(0, 3) == 0);
      ack  = ($urandom_range(0, 30) == 0);
      reti = ($urandom_range(0, 20) == 0);
      wr   = ($urandom_range(0, 6) == 0);
      wdata = 8'($urandom);
      case ($urandom_range(0, 3))
        0: addr = 8'h8B;
        1: addr = 8'($urandom);
        default: addr = 8'h0B;
      endcase
      step();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule